// File: doc/BRIEF.md
# Ping-Pong Hit Counter Group with Sparse Serial Readout

This block collects binary hit pulses from a group of pixels (256 by default) and reports them on one serial line, with no dead time between time slices. Every pixel owns two small saturating counters. At each slice boundary the two swap roles. One keeps accumulating hits for the new slice. The other holds the finished slice and is drained by a lowest-index-first priority encoder, which visits only pixels with a non-zero count. No trigger is involved: the hit inputs are plain per-cycle pulses.

Each slice yields one frame on the serial line. In timed mode a frame carries the address of every pixel that was hit. In imaging mode it carries the count of every such pixel, with no address. In both modes empty pixels are skipped, and an end marker word closes the frame. A per-pixel kill mask, loaded through a configuration shift register, silences pixels outside a region of interest. A calibration strobe adds one hit to every enabled pixel. A boundary that arrives while the previous frame is still being drained sets a sticky overflow flag.

Top module: `hitcount_sparse_rdout`

## Requirements
- R1: After a synchronous active-high reset, `ser_o` and `ovf_o` are 0 and the kill mask is all clear.
- R2: Hits seen while a bank is counting are reported in the frame that the next `slice_i` pulse starts. That `slice_i` pulse is what starts the frame.
- R3: A pixel counter stops at 31 and does not wrap.
- R4: A killed pixel never counts hits and never appears in a frame.
- R5: In timed mode (`img_mode_i`=0), each data word carries the 8-bit pixel index. Words come out in ascending index order.
- R6: In imaging mode (`img_mode_i`=1), each data word carries the pixel's count, zero-extended to 8 bits, and no address. Words still come out in ascending index order.
- R7: Pixels with a zero count produce no word. Every frame ends with one end word. A slice with no hits yields a frame that holds only the end word.
- R8: Each non-empty pixel produces exactly one data word per frame. Its counter is cleared once it has been read.
- R9: A `slice_i` pulse that arrives while a frame is still being sent sets `ovf_o`. `ovf_o` then stays set until reset.
- R10: One cycle of `cal_i` adds one hit to every pixel that is not killed.
- R11: Hits that arrive while the previous frame is being sent are counted, and they are reported in the following frame.
- R12: Word format on `ser_o`: the idle level is 0. Each word is 10 bits, sent MSB first: a start bit of 1, then a type bit (0 for data, 1 for end), then an 8-bit payload. The end word's payload is 0.
- R13: Each cycle of `cfg_en_i` shifts `cfg_bit_i` into the kill mask. After NPIX shifts, the first bit shifted in sits at pixel NPIX-1. A 1 kills the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NPIX | Per-pixel hit pulse, one hit per cycle high |
| slice_i | input | 1 | Time-slice boundary pulse |
| img_mode_i | input | 1 | 0 selects timed (address) words, 1 selects imaging (count) words |
| cal_i | input | 1 | Calibration strobe: one hit to every enabled pixel |
| cfg_en_i | input | 1 | Kill-mask shift enable |
| cfg_bit_i | input | 1 | Kill-mask serial data |
| ser_o | output | 1 | Serial word output |
| ovf_o | output | 1 | Sticky readout overflow flag |

## Verification
The hardest situation to reach is a slice boundary that lands while a frame is still in flight. A normal frame drains in tens of cycles. To produce one long enough to be interrupted, the stimulus fires the calibration strobe with most pixels enabled, which gives a frame of more than 250 words. It then pulses the boundary again 50 cycles into that frame. After the interrupted frame has drained, the bench runs an empty slice. That slice must produce a bare end word while the flag stays set.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_SCAN = 1'b1} rd_state_e;
  localparam logic WORD_START = 1'b1;
  localparam logic TYPE_DATA  = 1'b0;
  localparam logic TYPE_END   = 1'b1;
endpackage

// File: rtl/pix_prio_enc.sv
module pix_prio_enc #(
  parameter int N  = 256,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [AW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = AW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/pix_count_bank.sv
module pix_count_bank #(
  parameter int N  = 256,
  parameter int CW = 5,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hit_i,
  input  logic          cal_i,
  input  logic          swap_i,
  input  logic          cfg_en_i,
  input  logic          cfg_bit_i,
  input  logic          clr_en_i,
  input  logic [AW-1:0] clr_idx_i,
  output logic [N-1:0]  nz_o,
  output logic [CW-1:0] rd_cnt_o
);
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic                  sel_q;   // 0: bank A counts, bank B is read
  logic [N-1:0]          kill_q;
  logic [N-1:0][CW-1:0]  rdv;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      kill_q <= '0;
    end else begin
      if (swap_i) sel_q <= ~sel_q;
      if (cfg_en_i) kill_q <= {kill_q[N-2:0], cfg_bit_i};
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pix
    logic [CW-1:0] ca, cb;
    logic inc, clr_me;
    assign inc    = (hit_i[g] | cal_i) & ~kill_q[g];
    assign clr_me = swap_i | (clr_en_i && clr_idx_i == AW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ca <= '0;
        cb <= '0;
      end else if (!sel_q) begin
        if (inc && ca != MAXC) ca <= ca + 1'b1;
        if (clr_me) cb <= '0;
      end else begin
        if (inc && cb != MAXC) cb <= cb + 1'b1;
        if (clr_me) ca <= '0;
      end
    end

    assign rdv[g]  = sel_q ? ca : cb;
    assign nz_o[g] = (rdv[g] != '0) && !kill_q[g];

    // R3: a full counting counter holds its value until its bank is swapped out
    p_sat_r3: assert property (@(posedge clk) disable iff (rst)
      (ca == MAXC && !sel_q && !swap_i) |=> ca == MAXC);
    // R8: a counter that has been read out is empty on the next cycle
    p_clr_r8: assert property (@(posedge clk) disable iff (rst)
      (clr_en_i && clr_idx_i == AW'(g) && !swap_i) |=> rdv[g] == '0);
  end

  assign rd_cnt_o = rdv[clr_idx_i];

  // R4: the encoder never selects a killed pixel
  p_kill_r4: assert property (@(posedge clk) disable iff (rst)
    clr_en_i |-> !kill_q[clr_idx_i]);
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int WW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [WW-1:0] word_i,
  output logic          busy_o,
  output logic          ser_o
);
  localparam int CNTW = $clog2(WW + 1);

  logic [WW-1:0]   sh_q;
  logic [CNTW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      ser_o  <= 1'b0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= CNTW'(WW);
      ser_o  <= 1'b0;
    end else if (left_q != '0) begin
      ser_o  <= sh_q[WW-1];
      sh_q   <= {sh_q[WW-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end else begin
      ser_o  <= 1'b0;
    end
  end

  assign busy_o = (left_q != '0);

  // R12: a word is accepted only when the line has finished the previous one
  p_load_idle_r12: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);
  // R12: the first bit of every word on the line is the start bit
  p_start_bit_r12: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ##1 ser_o);
endmodule

// File: rtl/hitcount_sparse_rdout.sv
module hitcount_sparse_rdout #(
  parameter int NPIX = 256,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIX-1:0] hit_i,
  input  logic            slice_i,
  input  logic            img_mode_i,
  input  logic            cal_i,
  input  logic            cfg_en_i,
  input  logic            cfg_bit_i,
  output logic            ser_o,
  output logic            ovf_o
);
  import hc_pkg::*;

  localparam int AW = $clog2(NPIX);
  localparam int PW = (AW > CW) ? AW : CW;
  localparam int WW = PW + 2;

  rd_state_e       st_q;
  logic [NPIX-1:0] nz;
  logic            any_nz;
  logic [AW-1:0]   pick;
  logic [CW-1:0]   pick_cnt;
  logic            ser_busy;
  logic            load;
  logic            clr_en;
  logic [WW-1:0]   word;

  pix_count_bank #(.N(NPIX), .CW(CW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .hit_i(hit_i), .cal_i(cal_i), .swap_i(slice_i),
    .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i), .clr_en_i(clr_en),
    .clr_idx_i(pick), .nz_o(nz), .rd_cnt_o(pick_cnt)
  );

  pix_prio_enc #(.N(NPIX), .AW(AW)) u_enc (
    .req_i(nz), .any_o(any_nz), .idx_o(pick)
  );

  word_serializer #(.WW(WW)) u_ser (
    .clk(clk), .rst(rst), .load_i(load), .word_i(word),
    .busy_o(ser_busy), .ser_o(ser_o)
  );

  always_comb begin
    load   = 1'b0;
    clr_en = 1'b0;
    word   = '0;
    if (st_q == RD_SCAN && !slice_i && !ser_busy) begin
      load = 1'b1;
      if (any_nz) begin
        clr_en = 1'b1;
        word   = {WORD_START, TYPE_DATA,
                  img_mode_i ? PW'(pick_cnt) : PW'(pick)};
      end else begin
        word   = {WORD_START, TYPE_END, {PW{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= RD_IDLE;
      ovf_o <= 1'b0;
    end else if (slice_i) begin
      st_q <= RD_SCAN;
      if (st_q != RD_IDLE || ser_busy) ovf_o <= 1'b1;
    end else if (load && !any_nz) begin
      st_q <= RD_IDLE;
    end
  end

  // R9: a boundary during an unfinished frame raises the flag
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
    (slice_i && (st_q != RD_IDLE || ser_busy)) |=> ovf_o);
  // R9: the flag is sticky
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  // R2: a boundary always starts a frame scan
  p_slice_scan_r2: assert property (@(posedge clk) disable iff (rst)
    slice_i |=> st_q == RD_SCAN);
endmodule

// File: tb/tb_hitcount_sparse_rdout.sv
module tb_hitcount_sparse_rdout;
  localparam int N = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] hit_i = '0;
  logic slice_i = 1'b0, img_mode_i = 1'b0, cal_i = 1'b0;
  logic cfg_en_i = 1'b0, cfg_bit_i = 1'b0;
  logic ser_o, ovf_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hitcount_sparse_rdout dut (
    .clk(clk), .rst(rst), .hit_i(hit_i), .slice_i(slice_i),
    .img_mode_i(img_mode_i), .cal_i(cal_i), .cfg_en_i(cfg_en_i),
    .cfg_bit_i(cfg_bit_i), .ser_o(ser_o), .ovf_o(ovf_o)
  );

  // line monitor: words stored as {type, payload}
  logic [8:0] q[$];
  bit  eof_seen = 0;
  bit  inw = 0;
  int  nb = 0;
  logic [8:0] acc;

  always @(negedge clk) begin
    if (rst) begin
      inw = 0;
    end else if (!inw) begin
      if (ser_o) begin
        inw = 1; nb = 0; acc = '0;
      end
    end else begin
      acc = {acc[7:0], ser_o};
      nb++;
      if (nb == 9) begin
        q.push_back(acc);
        if (acc[8]) eof_seen = 1;
        inw = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic clear_mon();
    q.delete();
    eof_seen = 0;
  endtask

  task automatic hits(input logic [N-1:0] m, input int n);
    @(negedge clk); hit_i = m;
    repeat (n) @(negedge clk);
    hit_i = '0;
  endtask

  task automatic slice();
    @(negedge clk); slice_i = 1'b1;
    @(negedge clk); slice_i = 1'b0;
  endtask

  task automatic wait_eof(input string tag);
    int k = 0;
    while (!eof_seen && k < 20000) begin
      @(negedge clk); k++;
    end
    chk(eof_seen, {tag, " end word seen"}, eof_seen, 1);
    repeat (4) @(negedge clk);
  endtask

  // exp: expected payloads of data words in order; last word must be the end word
  task automatic check_frame(input int exp[$], input string tag);
    chk(q.size() == exp.size() + 1, {tag, " word count"}, q.size(), exp.size() + 1);
    for (int i = 0; i < exp.size() && i < q.size(); i++) begin
      chk(q[i][8] == 1'b0 && int'(q[i][7:0]) == exp[i], {tag, " data word"},
          int'(q[i]), exp[i]);
    end
    if (q.size() > 0)
      chk(q[q.size()-1] == 9'h100, {tag, " end word R7 R12"}, int'(q[q.size()-1]), 256);
  endtask

  task automatic load_kill(input logic [N-1:0] k);
    for (int j = N - 1; j >= 0; j--) begin
      @(negedge clk); cfg_en_i = 1'b1; cfg_bit_i = k[j];
    end
    @(negedge clk); cfg_en_i = 1'b0; cfg_bit_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(ser_o == 1'b0, "R1 ser_o after reset", ser_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf_o after reset", ovf_o, 0);
  endtask

  task automatic t_timed();
    logic [N-1:0] m;
    int e[$];
    img_mode_i = 1'b0;
    m = '0; m[3] = 1; hits(m, 2);
    m = '0; m[200] = 1; hits(m, 1);
    m = '0; m[17] = 1; hits(m, 4);
    clear_mon(); slice(); wait_eof("R2 R5");
    e = '{3, 17, 200};
    check_frame(e, "R5 R8 timed addresses");
  endtask

  task automatic t_imaging();
    logic [N-1:0] m;
    int e[$];
    img_mode_i = 1'b1;
    m = '0; m[250] = 1; hits(m, 1);
    m = '0; m[5] = 1; hits(m, 7);
    m = '0; m[9] = 1; hits(m, 40);
    clear_mon(); slice(); wait_eof("R6");
    e = '{7, 31, 1};
    check_frame(e, "R6 R3 imaging counts");
  endtask

  task automatic t_empty();
    int e[$];
    clear_mon(); slice(); wait_eof("R7");
    e = '{};
    check_frame(e, "R7 R8 empty slice");
  endtask

  task automatic t_deadtime();
    logic [N-1:0] m;
    int e[$];
    img_mode_i = 1'b1;
    m = '0; m[1] = 1; hits(m, 3);
    clear_mon(); slice();
    m = '0; m[40] = 1; hits(m, 2);   // during readout of the previous slice
    chk(eof_seen == 0, "R11 hits land while frame in flight", eof_seen, 0);
    wait_eof("R11 first");
    e = '{3};
    check_frame(e, "R11 first frame");
    clear_mon(); slice(); wait_eof("R11 second");
    e = '{2};
    check_frame(e, "R11 second frame");
  endtask

  task automatic t_kill_cal();
    logic [N-1:0] k, m;
    int e[$];
    img_mode_i = 1'b0;
    k = '0; k[3] = 1; k[17] = 1;
    load_kill(k);
    m = '0; m[3] = 1; m[17] = 1; m[18] = 1; hits(m, 2);
    clear_mon(); slice(); wait_eof("R4 R13");
    e = '{18};
    check_frame(e, "R4 R13 killed pixels silent");
    @(negedge clk); cal_i = 1'b1;
    @(negedge clk); cal_i = 1'b0;
    clear_mon(); slice(); wait_eof("R10");
    e = '{};
    for (int i = 0; i < N; i++) if (i != 3 && i != 17) e.push_back(i);
    check_frame(e, "R10 R4 calibration strobe");
    chk(ovf_o == 1'b0, "R9 no overflow in clean frames", ovf_o, 0);
  endtask

  task automatic t_overflow();
    int e[$];
    img_mode_i = 1'b0;
    @(negedge clk); cal_i = 1'b1;
    @(negedge clk); cal_i = 1'b0;
    clear_mon(); slice();
    repeat (50) @(negedge clk);
    chk(ovf_o == 1'b0, "R9 flag clear mid frame", ovf_o, 0);
    slice();
    chk(ovf_o == 1'b1, "R9 flag set on early boundary", ovf_o, 1);
    repeat (200) @(negedge clk);
    clear_mon(); slice(); wait_eof("R9 recovery");
    e = '{};
    check_frame(e, "R9 frame after overflow");
    chk(ovf_o == 1'b1, "R9 flag sticky", ovf_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timed();
    t_imaging();
    t_empty();
    t_deadtime();
    t_kill_cal();
    t_overflow();
    finish_run();
  end
endmodule